// File: doc/BRIEF.md
# Colour Kill Controller

This block decides whether the incoming video carries colour or should be treated as monochrome. On every line strobe it compares the demodulated burst magnitudes of both colour-difference axes against a programmable threshold. A line counts as burstless only when both magnitudes are below that threshold. The block counts burstless lines across each field and decides at each field strobe whether colour should be suppressed.

When a field holds at least the kill limit of burstless lines, the kill engages at that field strobe, so it covers the following field. Once engaged, it is released only after a field finishes below the limit, and then only when vertical blanking is next seen. While the kill is engaged, both colour-difference outputs carry the neutral mid-scale code and luminance passes through unchanged. The block also exports the per-line burstless flag for downstream field identification, and a status bit that reports colour presence.

Top module: `chroma_kill_ctrl`

## Requirements
- R1: At each line strobe, `line_noburst` is set to 1 exactly when `burst_u_mag < burst_thresh` and `burst_v_mag < burst_thresh` (both strictly below), and to 0 otherwise. The new value appears in the cycle after the strobe and is held until the next line strobe.
- R2: The burstless-line count advances by at most one per line strobe, and only on a strobe whose R1 condition is true. Low magnitudes without a strobe leave the count unchanged.
- R3: When a field strobe sees a count, including a burstless line strobed in the same cycle, of at least `KILL_LINES`, `kill_active` is 1 from the cycle after that strobe. It never rises between field strobes.
- R4: While `kill_active` is 1, `u_out` and `v_out` equal `2**(DATA_W-1)` (0x80 for 8 bits) one cycle later. `y_out` always equals `y_in` delayed by one cycle. While `kill_active` is 0, `u_out` and `v_out` equal `u_in` and `v_in` delayed by one cycle.
- R5: While kill is engaged, a field strobe with a count below `KILL_LINES` arms a release. `kill_active` falls in the cycle after the first later cycle in which `vblank` is 1. A field strobe that reaches the limit before that point cancels the armed release.
- R6: `color_present` is always the inverse of `kill_active`.
- R7: The count saturates at `KILL_LINES`, so extra burstless lines never wrap it. It restarts from zero after every field strobe, so lines from separate fields never add up.
- R8: After reset, `kill_active` is 0, `color_present` is 1, `line_noburst` is 0 and all video outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse per video line |
| field_stb | input | 1 | One-cycle pulse at the end of each field |
| vblank | input | 1 | High during vertical blanking |
| burst_u_mag | input | MAG_W | Burst magnitude on the U axis |
| burst_v_mag | input | MAG_W | Burst magnitude on the V axis |
| burst_thresh | input | MAG_W | Programmable burst presence threshold |
| y_in | input | DATA_W | Luminance sample |
| u_in | input | DATA_W | U colour-difference sample, offset binary |
| v_in | input | DATA_W | V colour-difference sample, offset binary |
| y_out | output | DATA_W | Registered luminance |
| u_out | output | DATA_W | Registered U, neutral when killed |
| v_out | output | DATA_W | Registered V, neutral when killed |
| line_noburst | output | 1 | Burstless flag of the latest line |
| kill_active | output | 1 | Colour kill engaged |
| color_present | output | 1 | Colour video detected |

## Verification
The bench builds the block with `KILL_LINES` = 6, `MAG_W` = 10 and `DATA_W` = 8. The counter width then comes out at three bits. With that limit, fields of only a few lines can reach both sides of the kill boundary (five and six lines). A ten-line field would wrap a non-saturating three-bit counter to a value below the limit, so it exposes any loss of saturation. Short fields also make it practical to reach armed releases, cancelled releases and the vblank-gated drop within a small cycle budget.

// File: rtl/ck_pkg.sv
package ck_pkg;

  typedef enum logic [1:0] {
    CK_COLOUR   = 2'd0,
    CK_KILLED   = 2'd1,
    CK_REL_WAIT = 2'd2
  } ck_state_t;

  function automatic int unsigned ck_cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/ck_line_detect.sv
module ck_line_detect #(
  parameter int unsigned MAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_stb,
  input  logic [MAG_W-1:0] u_mag,
  input  logic [MAG_W-1:0] v_mag,
  input  logic [MAG_W-1:0] thresh,
  output logic             below_now,
  output logic             flag_q
);

  assign below_now = (u_mag < thresh) && (v_mag < thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (line_stb) begin
      flag_q <= below_now;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_stb |=> $stable(flag_q)) else $error("flag changed without line strobe"); // R1

endmodule

// File: rtl/ck_field_counter.sv
module ck_field_counter #(
  parameter int unsigned KILL_LINES = 127,
  parameter int unsigned CNT_W      = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic line_hit,
  input  logic field_stb,
  output logic reached
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(KILL_LINES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (line_hit && (cnt_q < LIMIT)) begin
      cnt_nx = cnt_q + CNT_W'(1);
    end
  end

  assign reached = field_stb && (cnt_nx >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (field_stb) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT) else $error("count beyond limit"); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    field_stb |=> (cnt_q == '0)) else $error("count not cleared"); // R7
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!field_stb && !line_hit) |=> $stable(cnt_q)) else $error("count moved without hit"); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!field_stb && line_hit && (cnt_q < LIMIT)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)))
    else $error("count step wrong"); // R2

endmodule

// File: rtl/ck_kill_fsm.sv
module ck_kill_fsm
  import ck_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic field_stb,
  input  logic reached,
  input  logic vblank,
  output logic kill
);

  ck_state_t st_q;
  ck_state_t st_nx;

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      CK_COLOUR: begin
        if (field_stb && reached) st_nx = CK_KILLED;
      end
      CK_KILLED: begin
        if (field_stb && !reached) st_nx = CK_REL_WAIT;
      end
      CK_REL_WAIT: begin
        if (field_stb) begin
          st_nx = reached ? CK_KILLED : CK_REL_WAIT;
        end else if (vblank) begin
          st_nx = CK_COLOUR;
        end
      end
      default: st_nx = CK_COLOUR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= CK_COLOUR;
    end else begin
      st_q <= st_nx;
    end
  end

  assign kill = (st_q != CK_COLOUR);

  AST_KILL_ONLY_AT_FIELD: assert property (@(posedge clk) disable iff (rst)
    (!kill && !(field_stb && reached)) |=> !kill) else $error("kill rose off a field strobe"); // R3
  AST_KILL_ARM: assert property (@(posedge clk) disable iff (rst)
    (field_stb && reached) |=> kill) else $error("kill not engaged"); // R3
  AST_KILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (kill && !vblank) |=> kill) else $error("kill released outside blanking"); // R5
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (st_q == CK_COLOUR) || (st_q == CK_KILLED) || (st_q == CK_REL_WAIT))
    else $error("illegal state"); // R5

endmodule

// File: rtl/ck_video_gate.sv
module ck_video_gate #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NCH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] c_in  [NCH],
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] c_out [NCH]
);

  localparam logic [DATA_W-1:0] NEUTRAL = DATA_W'(1) << (DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out <= '0;
    end else begin
      y_out <= y_in;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chroma
    always_ff @(posedge clk) begin
      if (rst) begin
        c_out[ch] <= '0;
      end else begin
        c_out[ch] <= kill ? NEUTRAL : c_in[ch];
      end
    end

    AST_CHROMA_BLACK: assert property (@(posedge clk) disable iff (rst)
      kill |=> (c_out[ch] == NEUTRAL)) else $error("chroma not neutral"); // R4
    AST_CHROMA_PASS: assert property (@(posedge clk) disable iff (rst)
      !kill |=> (c_out[ch] == $past(c_in[ch]))) else $error("chroma not passed"); // R4
  end

  AST_LUMA_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (y_out == $past(y_in))) else $error("luma altered"); // R4

endmodule

// File: rtl/chroma_kill_ctrl.sv
module chroma_kill_ctrl #(
  parameter int unsigned MAG_W      = 10,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned KILL_LINES = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_stb,
  input  logic              field_stb,
  input  logic              vblank,
  input  logic [MAG_W-1:0]  burst_u_mag,
  input  logic [MAG_W-1:0]  burst_v_mag,
  input  logic [MAG_W-1:0]  burst_thresh,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] u_in,
  input  logic [DATA_W-1:0] v_in,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] u_out,
  output logic [DATA_W-1:0] v_out,
  output logic              line_noburst,
  output logic              kill_active,
  output logic              color_present
);

  localparam int unsigned CNT_W = ck_pkg::ck_cnt_width(KILL_LINES);
  localparam int unsigned NCH   = 2;

  logic              below_now;
  logic              line_hit;
  logic              reached;
  logic              kill;
  logic [DATA_W-1:0] c_in  [NCH];
  logic [DATA_W-1:0] c_out [NCH];

  ck_line_detect #(.MAG_W(MAG_W)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .line_stb (line_stb),
    .u_mag    (burst_u_mag),
    .v_mag    (burst_v_mag),
    .thresh   (burst_thresh),
    .below_now(below_now),
    .flag_q   (line_noburst)
  );

  assign line_hit = line_stb && below_now;

  ck_field_counter #(.KILL_LINES(KILL_LINES), .CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .line_hit (line_hit),
    .field_stb(field_stb),
    .reached  (reached)
  );

  ck_kill_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .field_stb(field_stb),
    .reached  (reached),
    .vblank   (vblank),
    .kill     (kill)
  );

  assign c_in[0] = u_in;
  assign c_in[1] = v_in;

  ck_video_gate #(.DATA_W(DATA_W), .NCH(NCH)) u_gate (
    .clk  (clk),
    .rst  (rst),
    .kill (kill),
    .y_in (y_in),
    .c_in (c_in),
    .y_out(y_out),
    .c_out(c_out)
  );

  assign u_out         = c_out[0];
  assign v_out         = c_out[1];
  assign kill_active   = kill;
  assign color_present = !kill;

endmodule

// File: tb/chroma_kill_ctrl_test.sv
module chroma_kill_ctrl_test;

  localparam int MAG_W  = 10;
  localparam int DATA_W = 8;
  localparam int KL     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_stb = 1'b0, field_stb = 1'b0, vblank = 1'b0;
  logic [MAG_W-1:0]  u_mag = '0, v_mag = '0, thr = 10'd100;
  logic [DATA_W-1:0] y_in = '0, u_in = '0, v_in = '0;
  logic [DATA_W-1:0] y_out, u_out, v_out;
  logic line_noburst, kill_active, color_present;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  chroma_kill_ctrl #(.MAG_W(MAG_W), .DATA_W(DATA_W), .KILL_LINES(KL)) uut (
    .clk(clk), .rst(rst), .line_stb(line_stb), .field_stb(field_stb), .vblank(vblank),
    .burst_u_mag(u_mag), .burst_v_mag(v_mag), .burst_thresh(thr),
    .y_in(y_in), .u_in(u_in), .v_in(v_in),
    .y_out(y_out), .u_out(u_out), .v_out(v_out),
    .line_noburst(line_noburst), .kill_active(kill_active), .color_present(color_present)
  );

  // {u_mag, v_mag, threshold, expected flag}
  localparam logic [30:0] VEC [0:5] = '{
    {10'd10,  10'd20,  10'd100, 1'b1},
    {10'd100, 10'd5,   10'd100, 1'b0},
    {10'd5,   10'd100, 10'd100, 1'b0},
    {10'd99,  10'd99,  10'd100, 1'b1},
    {10'd0,   10'd0,   10'd0,   1'b0},
    {10'd300, 10'd400, 10'd200, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_line(input logic [MAG_W-1:0] u, input logic [MAG_W-1:0] v);
    @(negedge clk);
    u_mag = u; v_mag = v; line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
  endtask

  task automatic lines(input int n, input logic burstless);
    for (int i = 0; i < n; i++) begin
      if (burstless) do_line(10'd3, 10'd4);
      else do_line(10'd300, 10'd300);
    end
  endtask

  task automatic do_field(input logic vb);
    @(negedge clk);
    field_stb = 1'b1; vblank = vb;
    @(negedge clk);
    field_stb = 1'b0; vblank = 1'b0;
  endtask

  task automatic vb_pulse();
    @(negedge clk);
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk("R8 kill", kill_active, 0);
    chk("R8 status", color_present, 1);
    chk("R8 flag", line_noburst, 0);
    chk("R8 u_out", u_out, 0);

    // R1 comparator vectors
    for (int i = 0; i < 6; i++) begin
      thr = VEC[i][10:1];
      do_line(VEC[i][30:21], VEC[i][20:11]);
      chk("R1 flag", line_noburst, VEC[i][0]);
    end
    thr = 10'd100;
    do_field(1'b0);
    chk("R3 no kill after table", kill_active, 0);

    // R1 hold between strobes
    do_line(10'd1, 10'd1);
    @(negedge clk); u_mag = 10'd500; v_mag = 10'd500;
    repeat (3) @(negedge clk);
    chk("R1 hold", line_noburst, 1);
    do_field(1'b0);

    // R4 pass-through while colour
    @(negedge clk); y_in = 8'h21; u_in = 8'h33; v_in = 8'hC4;
    @(negedge clk);
    chk("R4 y pass", y_out, 8'h21);
    chk("R4 u pass", u_out, 8'h33);
    chk("R4 v pass", v_out, 8'hC4);

    // R3 boundary: KL-1 lines, no kill
    lines(KL - 1, 1'b1);
    do_field(1'b0);
    chk("R3 below limit", kill_active, 0);

    // R2 low magnitudes without strobes do not count
    lines(KL - 1, 1'b1);
    @(negedge clk); u_mag = 10'd1; v_mag = 10'd1;
    repeat (10) @(negedge clk);
    lines(1, 1'b0);
    do_field(1'b0);
    chk("R2 no count without strobe", kill_active, 0);

    // R3 KL lines: kill only after field strobe
    lines(KL, 1'b1);
    chk("R3 not before field", kill_active, 0);
    do_field(1'b0);
    chk("R3 kill engaged", kill_active, 1);
    chk("R6 status low", color_present, 0);
    @(negedge clk); y_in = 8'h5A; u_in = 8'h11; v_in = 8'hEE;
    @(negedge clk);
    chk("R4 u black", u_out, 8'h80);
    chk("R4 v black", v_out, 8'h80);
    chk("R4 y pass killed", y_out, 8'h5A);

    // R5 release waits for vblank
    lines(2, 1'b1);
    do_field(1'b0);
    chk("R5 still killed after field", kill_active, 1);
    repeat (4) @(negedge clk);
    chk("R5 no drop without vblank", kill_active, 1);
    vb_pulse();
    chk("R5 released in vblank", kill_active, 0);
    chk("R6 status high", color_present, 1);

    // R7 saturation: 10 lines on a 3-bit counter
    lines(10, 1'b1);
    do_field(1'b0);
    chk("R7 saturated kill", kill_active, 1);

    // R5 release cancelled by a reaching field
    lines(1, 1'b1);
    do_field(1'b0);
    lines(KL, 1'b1);
    do_field(1'b0);
    vb_pulse();
    chk("R5 cancelled release", kill_active, 1);
    do_field(1'b0);
    vb_pulse();
    chk("R5 release after cancel", kill_active, 0);

    // R7 clear across fields: 4 + 4 lines, no kill
    lines(4, 1'b1);
    do_field(1'b0);
    lines(4, 1'b1);
    do_field(1'b0);
    chk("R7 cleared per field", kill_active, 0);

    // R3 line on same cycle as field strobe counts
    lines(KL - 1, 1'b1);
    @(negedge clk);
    u_mag = 10'd2; v_mag = 10'd2; line_stb = 1'b1; field_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0; field_stb = 1'b0;
    chk("R3 same-cycle line", kill_active, 1);

    // R8 reset mid-kill
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 reset clears kill", kill_active, 0);
    chk("R8 reset clears flag", line_noburst, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule